// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Sequencer

This block is the device-side control logic of a byte-wide nonvolatile memory that is written a page at a time. It watches a parallel bus with active-low chip enable, write enable and output enable, all sampled on the block clock. A write strobe is the interval in which chip enable and write enable are both low. Every page write opens with a three-strobe unlock sequence. The strobes that follow are byte loads into a 128-byte page buffer. The load phase closes when no new strobe starts within a timeout. A timed internal program cycle then copies the whole page into a behavioural array, one byte per clock.

While the program cycle runs, a read returns a status word and not array data. Software polls that word to learn when the cycle is done. Once the cycle ends the block is locked again, and the next page needs a fresh unlock. Both timeouts are set in clock cycles by parameters. The array size is a parameter, and bus address bits above the array size are ignored for array access.

Top module: `eep_page_writer`

## Requirements
- R1: After a synchronous active-low reset the block is idle and locked, and `data_oe` is 0.
- R2: `data_oe` is 1 exactly when `ce_n` and `oe_n` are both low. Outside a program cycle, `data_out` then carries the array byte at `addr[ARR_AW-1:0]`.
- R3: Unlocking takes three consecutive strobes: 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Any other strobe while the sequence is partly done discards it. Strobes given while locked never change the array.
- R4: A strobe's address is taken in the first clock where `ce_n` and `we_n` are both low. Later address changes within the strobe are ignored.
- R5: A strobe's data is the value on `data_in` in the last clock before either enable rises. Changes after that are ignored.
- R6: The load phase lasts while each new strobe starts no more than BLCO_CYC cycles after the previous one ends. If a strobe ends on the clock edge numbered 0 and none follows, reads show the program status from edge BLCO_CYC+2 onward.
- R7: Bits [6:0] of a load's address select the byte within the page. A second load to the same byte replaces the first. Bits [ARR_AW-1:7] of the last load select the page that is programmed.
- R8: Page bytes that received no load during the load phase are programmed as 0xFF.
- R9: The program cycle lasts exactly PROG_CYC cycles and cannot be aborted. Strobes during it, including a complete unlock sequence, have no effect.
- R10: During the program cycle a read returns {~b7, T, 6'b000000}, where b7 is bit 7 of the last byte loaded and T inverts after every read that completes during the cycle.
- R11: After the program cycle the block is locked again, and byte loads without a new unlock are ignored.
- R12: An unlock followed by no byte load before the timeout returns to idle without starting a program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 16 | Bus address |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data or program status |
| data_oe | output | 1 | High while the block drives the data bus |

## Verification
A strobe's load reaches the sequencer two clocks after the enables rise. The load window timer starts counting one clock after that. For this reason the status word first shows BLCO_CYC+2 edges after the strobe ends, and array data returns PROG_CYC edges later. The bench holds a read open across both boundaries and samples on falling edges one cycle before and one cycle after each. Status reads for the toggle bit are short, and the value is sampled on the falling edge after output enable goes low. Page contents are compared only after the full timeout plus program time has passed.

// File: rtl/eep_pkg.sv
// Shared constants and types for the page-buffered EEPROM sequencer.
// Assumes a 16-bit bus address and 8-bit data.
package eep_pkg;
    localparam int          BUS_AW   = 16;
    localparam logic [15:0] UNLK_AD1 = 16'h5555;
    localparam logic [15:0] UNLK_AD2 = 16'h2AAA;
    localparam logic [7:0]  UNLK_DA1 = 8'hAA;
    localparam logic [7:0]  UNLK_DA2 = 8'h55;
    localparam logic [7:0]  UNLK_DA3 = 8'hA0;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_PROG = 2'd2
    } seq_state_e;
endpackage

// File: rtl/eep_bus_cap.sv
// Write strobe capture. A strobe is the span where ce_n and we_n are both
// low. The address is taken on the strobe's first clock and the data on its
// last clock. A one-cycle load pulse follows the strobe's end.
// Assumes the bus pins are synchronous to clk.
module eep_bus_cap
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [BUS_AW-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              strobe_o,
    output logic              ld_v_o,
    output logic [BUS_AW-1:0] ld_addr_o,
    output logic [7:0]        ld_data_o
);
    logic              wr_act;
    logic              wr_q;
    logic [BUS_AW-1:0] addr_lat;
    logic [7:0]        data_lat;

    assign wr_act   = ~ce_n & ~we_n;
    assign strobe_o = wr_act;

    // Track the strobe, latch address and data, and emit the load pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            ld_v_o    <= 1'b0;
            addr_lat  <= '0;
            data_lat  <= '0;
            ld_addr_o <= '0;
            ld_data_o <= '0;
        end else begin
            wr_q   <= wr_act;
            ld_v_o <= wr_q & ~wr_act;
            if (wr_act && !wr_q) addr_lat <= addr_i;
            if (wr_act)          data_lat <= data_i;
            if (wr_q && !wr_act) begin
                ld_addr_o <= addr_lat;
                ld_data_o <= data_lat;
            end
        end
    end

    // R5
    ld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_v_o |=> !ld_v_o);
    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && wr_act) |=> $stable(addr_lat));
endmodule

// File: rtl/eep_unlock.sv
// Unlock sequence checker. It walks the three fixed address/data pairs and
// pulses open_o combinationally on the load that completes the sequence.
// Any mismatch sends it back to the start. It is held at the start while
// en_i is low.
module eep_unlock
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ld_v_i,
    input  logic [BUS_AW-1:0] ld_addr_i,
    input  logic [7:0]        ld_data_i,
    output logic              open_o
);
    logic [1:0] step;
    logic       hit;

    // Match the current load against the pair expected at this step
    always_comb begin
        unique case (step)
            2'd0:    hit = (ld_addr_i == UNLK_AD1) && (ld_data_i == UNLK_DA1);
            2'd1:    hit = (ld_addr_i == UNLK_AD2) && (ld_data_i == UNLK_DA2);
            2'd2:    hit = (ld_addr_i == UNLK_AD1) && (ld_data_i == UNLK_DA3);
            default: hit = 1'b0;
        endcase
    end

    assign open_o = en_i & ld_v_i & hit & (step == 2'd2);

    // Advance on a match, restart on a mismatch or when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            step <= 2'd0;
        end else if (ld_v_i) begin
            step <= (hit && step != 2'd2) ? step + 2'd1 : 2'd0;
        end
    end

    // R3
    step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ld_v_i) |=> $stable(step));
    // R3
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |=> (step == 2'd0));
endmodule

// File: rtl/eep_page_buf.sv
// Page buffer with a per-byte loaded mask. A read of a byte that was never
// loaded since the last clear returns 0xFF. Clear wins over write.
module eep_page_buf #(
    parameter int PAGE_AW = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               wr_i,
    input  logic [PAGE_AW-1:0] wr_off_i,
    input  logic [7:0]         wr_data_i,
    input  logic [PAGE_AW-1:0] rd_off_i,
    output logic [7:0]         rd_byte_o,
    output logic               any_o
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    logic [7:0]            bytes [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded;

    // Store load data; contents need no reset because the mask guards them
    always_ff @(posedge clk) begin
        if (wr_i) bytes[wr_off_i] <= wr_data_i;
    end

    // Maintain which offsets hold loaded data
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) loaded <= '0;
        else if (wr_i)       loaded[wr_off_i] <= 1'b1;
    end

    assign rd_byte_o = loaded[rd_off_i] ? bytes[rd_off_i] : 8'hFF;
    assign any_o     = |loaded;

    // R8
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !wr_i) |=> $stable(loaded));
endmodule

// File: rtl/eep_page_writer.sv
// Page-buffered EEPROM write sequencer (top). Unlock, page load with an
// inactivity timeout, then a fixed-length program cycle that writes one
// page byte per clock into a behavioural array. During the program cycle a
// read returns a status word. Assumes PROG_CYC > 2**PAGE_AW and
// ARR_AW > PAGE_AW.
module eep_page_writer
    import eep_pkg::*;
#(
    parameter int ARR_AW   = 11,
    parameter int PAGE_AW  = 7,
    parameter int BLCO_CYC = 200,
    parameter int PROG_CYC = 600
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [15:0] addr,
    input  logic [7:0]  data_in,
    output logic [7:0]  data_out,
    output logic        data_oe
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int PG_W       = ARR_AW - PAGE_AW;
    localparam int DEPTH      = 1 << ARR_AW;
    localparam int TW         = $clog2(BLCO_CYC + 1);
    localparam int PW         = $clog2(PROG_CYC + 1);

    seq_state_e        st;
    logic [TW-1:0]     tmr;
    logic [PW-1:0]     pcnt;
    logic [PG_W-1:0]   page_q;
    logic [7:0]        last_d;
    logic              tog;
    logic              rd_q;
    logic              rd_act;
    logic [7:0]        mem [DEPTH];

    logic              strobe;
    logic              ld_v;
    logic [BUS_AW-1:0] ld_addr;
    logic [7:0]        ld_data;
    logic              open_p;
    logic [7:0]        buf_byte;
    logic              buf_any;

    eep_bus_cap u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .addr_i   (addr),
        .data_i   (data_in),
        .strobe_o (strobe),
        .ld_v_o   (ld_v),
        .ld_addr_o(ld_addr),
        .ld_data_o(ld_data)
    );

    eep_unlock u_unlk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (st == SEQ_IDLE),
        .ld_v_i   (ld_v),
        .ld_addr_i(ld_addr),
        .ld_data_i(ld_data),
        .open_o   (open_p)
    );

    eep_page_buf #(.PAGE_AW(PAGE_AW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (open_p),
        .wr_i     (st == SEQ_LOAD && ld_v),
        .wr_off_i (ld_addr[PAGE_AW-1:0]),
        .wr_data_i(ld_data),
        .rd_off_i (pcnt[PAGE_AW-1:0]),
        .rd_byte_o(buf_byte),
        .any_o    (buf_any)
    );

    // Sequencer: idle -> load (timeout) -> program -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SEQ_IDLE;
            tmr    <= '0;
            pcnt   <= '0;
            page_q <= '0;
            last_d <= '0;
        end else begin
            unique case (st)
                SEQ_IDLE: begin
                    if (open_p) begin
                        st  <= SEQ_LOAD;
                        tmr <= '0;
                    end
                end
                SEQ_LOAD: begin
                    if (ld_v) begin
                        page_q <= ld_addr[ARR_AW-1:PAGE_AW];
                        last_d <= ld_data;
                        tmr    <= '0;
                    end else if (strobe) begin
                        tmr <= '0;
                    end else if (tmr == TW'(BLCO_CYC - 1)) begin
                        st   <= buf_any ? SEQ_PROG : SEQ_IDLE;
                        pcnt <= '0;
                        tmr  <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                SEQ_PROG: begin
                    if (pcnt == PW'(PROG_CYC - 1)) st <= SEQ_IDLE;
                    else                           pcnt <= pcnt + 1'b1;
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    // Commit one page byte per clock during the first part of the program cycle
    always_ff @(posedge clk) begin
        if (st == SEQ_PROG && pcnt < PW'(PAGE_BYTES))
            mem[{page_q, pcnt[PAGE_AW-1:0]}] <= buf_byte;
    end

    assign rd_act = ~ce_n & ~oe_n;

    // Invert the status toggle bit after each read that completes while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            tog  <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (st == SEQ_PROG && rd_q && !rd_act) tog <= ~tog;
        end
    end

    // Read mux: status while programming, array data otherwise
    always_comb begin
        data_oe = rd_act;
        if (!rd_act)              data_out = 8'h00;
        else if (st == SEQ_PROG)  data_out = {~last_d[7], tog, 6'b000000};
        else                      data_out = mem[addr[ARR_AW-1:0]];
    end

    // R9
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_PROG && pcnt != PW'(PROG_CYC - 1)) |=> (st == SEQ_PROG));
    // R9
    prog_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_PROG) |=> (st == SEQ_PROG || st == SEQ_IDLE));
    // R12
    prog_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_LOAD) |=> (st != SEQ_PROG || buf_any));
    // R10
    tog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != SEQ_PROG) |=> $stable(tog));
    // R11
    lock_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_PROG) |=> (st != SEQ_LOAD));
endmodule

// File: tb/eep_page_writer_tb.sv
module eep_page_writer_tb;
    localparam int BLCO  = 200;
    localparam int PROG  = 600;
    localparam int DEPTH = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        doe;

    int n_cmp = 0;
    int n_err = 0;

    logic [7:0]  mdl   [DEPTH];
    logic [7:0]  bbuf  [128];
    bit          bmask [128];
    logic [15:0] last_a;
    logic [7:0]  last_d;
    logic        exp_tog = 1'b0;

    always #4 clk = ~clk;

    eep_page_writer #(.ARR_AW(11), .PAGE_AW(7), .BLCO_CYC(BLCO), .PROG_CYC(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .data_in(din), .data_out(dout), .data_oe(doe)
    );

    function automatic logic [7:0] status_word(input logic [7:0] d, input logic t);
        return {~d[7], t, 6'b000000};
    endfunction

    function automatic logic [15:0] pa(input int pg, input int off);
        return 16'((pg << 7) | off);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic do_load(input logic [15:0] a, input logic [7:0] d);
        strobe(a, d);
        bbuf[a[6:0]] = d; bmask[a[6:0]] = 1'b1; last_a = a; last_d = d;
    endtask

    task automatic unlock();
        strobe(16'h5555, 8'hAA);
        strobe(16'h2AAA, 8'h55);
        strobe(16'h5555, 8'hA0);
        for (int i = 0; i < 128; i++) bmask[i] = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v, output logic e);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); v = dout; e = doe; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic apply_model();
        for (int i = 0; i < 128; i++)
            mdl[{last_a[10:7], i[6:0]}] = bmask[i] ? bbuf[i] : 8'hFF;
    endtask

    task automatic wait_commit();
        repeat (BLCO + PROG + 10) @(negedge clk);
        apply_model();
    endtask

    task automatic verify_page(input int pg, input string req);
        logic [7:0] v; logic e;
        for (int i = 0; i < 128; i++) begin
            rd(pa(pg, i), v, e);
            chk(req, v, mdl[pa(pg, i)]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v; logic e;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) bmask[i] = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 oe in reset", {7'd0, doe}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", {7'd0, doe}, 8'h00);

        // R2: output enable qualification
        ce_n = 1'b0; oe_n = 1'b1; @(negedge clk);
        chk("R2 ce only", {7'd0, doe}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0; @(negedge clk);
        chk("R2 oe only", {7'd0, doe}, 8'h00);
        ce_n = 1'b0; @(negedge clk);
        chk("R2 both low", {7'd0, doe}, 8'h01);
        ce_n = 1'b1; oe_n = 1'b1;

        // R8: partial page, unloaded bytes become FF
        unlock();
        do_load(pa(0, 0), 8'h11); do_load(pa(0, 1), 8'h22);
        do_load(pa(0, 2), 8'h33); do_load(pa(0, 3), 8'hC4);
        wait_commit();
        verify_page(0, "R8 page0");

        // R3: broken sequence and loads while locked change nothing
        strobe(16'h5555, 8'hAA); strobe(16'h2AAA, 8'h55); strobe(16'h5555, 8'hA1);
        strobe(pa(0, 10), 8'h99);
        strobe(pa(0, 11), 8'h77);
        repeat (BLCO + PROG + 10) @(negedge clk);
        rd(pa(0, 10), v, e); chk("R3 bad unlock", v, 8'hFF);
        rd(pa(0, 11), v, e); chk("R3 locked load", v, 8'hFF);

        // R12: unlock with no loads starts no program cycle
        unlock();
        addr = pa(0, 0); ce_n = 1'b0; oe_n = 1'b0;
        repeat (BLCO + 2) @(negedge clk);
        chk("R12 no program", dout, 8'h11);
        repeat (20) @(negedge clk);
        chk("R12 still idle", dout, 8'h11);
        ce_n = 1'b1; oe_n = 1'b1;

        // R6, R9: window kept alive near its limit, then exact status timing
        unlock();
        for (int k = 0; k < 4; k++) begin
            do_load(pa(1, 8 * k), 8'(8'h40 + k));
            repeat (BLCO - 11) @(negedge clk);
        end
        do_load(pa(1, 100), 8'h5A);
        addr = pa(0, 0); ce_n = 1'b0; oe_n = 1'b0;
        repeat (BLCO + 1) @(negedge clk);
        chk("R6 before timeout", dout, 8'h11);
        @(negedge clk);
        chk("R6 status at timeout", dout, status_word(8'h5A, exp_tog));
        repeat (PROG - 1) @(negedge clk);
        chk("R9 last busy cycle", dout, status_word(8'h5A, exp_tog));
        @(negedge clk);
        chk("R9 data after program", dout, 8'h11);
        ce_n = 1'b1; oe_n = 1'b1;
        apply_model();
        verify_page(1, "R6 page1 kept all loads");

        // R4, R5, R7, R9, R10, R11
        unlock();
        do_load(pa(2, 9), 8'h10);
        do_load(pa(2, 9), 8'h20);
        @(negedge clk); addr = pa(5, 1); din = 8'hAA; ce_n = 1'b0;
        @(negedge clk); addr = pa(2, 3); we_n = 1'b0;
        @(negedge clk); addr = pa(6, 7); din = 8'h3C;
        @(negedge clk); we_n = 1'b1; din = 8'hC3;
        @(negedge clk); ce_n = 1'b1;
        bbuf[3] = 8'h3C; bmask[3] = 1'b1;
        do_load(pa(3, 5), 8'hE7);
        repeat (BLCO + 5) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            rd(pa(3, 5), v, e);
            chk("R10 status toggle", v, status_word(8'hE7, exp_tog));
            exp_tog = ~exp_tog;
        end
        strobe(16'h5555, 8'hAA); strobe(16'h2AAA, 8'h55); strobe(16'h5555, 8'hA0);
        strobe(pa(3, 20), 8'h00);
        repeat (PROG) @(negedge clk);
        apply_model();
        rd(pa(3, 20), v, e); chk("R9 load while busy", v, 8'hFF);
        rd(pa(3, 3), v, e);  chk("R4 R5 captured byte", v, 8'h3C);
        rd(pa(3, 1), v, e);  chk("R4 early address ignored", v, 8'hFF);
        rd(pa(3, 7), v, e);  chk("R4 late address ignored", v, 8'hFF);
        rd(pa(3, 9), v, e);  chk("R7 overwrite", v, 8'h20);
        verify_page(3, "R7 last page");
        strobe(pa(3, 21), 8'h12);
        repeat (BLCO + PROG + 10) @(negedge clk);
        rd(pa(3, 21), v, e); chk("R11 relocked", v, 8'hFF);

        // R7, R8: random pages, offsets, overwrites and gaps
        for (int t = 0; t < 4; t++) begin
            int pg, n;
            pg = $urandom_range(4, 15);
            n  = $urandom_range(1, 24);
            unlock();
            for (int j = 0; j < n; j++) begin
                int off, lp;
                off = $urandom_range(0, 127);
                lp  = (j == n - 1) ? pg : $urandom_range(0, 15);
                repeat ($urandom_range(0, 40)) @(negedge clk);
                do_load(pa(lp, off), 8'($urandom));
            end
            wait_commit();
            verify_page(pg, "R7 R8 random page");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule